// File: doc/BRIEF.md
# Edge-Event Timestamping Engine

The engine watches a wide bank of input lines, organised as slices of 32 lines each. Software picks the lines of interest through one enable word per slice. When an enabled line changes while the engine is switched on, the engine records an event into a 16-entry queue. Each event holds four things: the value of a free-running 64-bit tick counter, the slice index, and the full 32-bit value of that slice both before and after the change. A line's global number is its slice index times 32 plus its bit position, so software recovers the changed lines and their edge direction from the two snapshots.

Software reads the oldest queued event through a set of head registers. It discards that event with an explicit pop command. A status register reports how many events are waiting and keeps a sticky flag that records lost events. A level interrupt asks for service once the number of waiting events reaches a programmable threshold.

Register map, byte offsets on a 32-bit access port:
- 0x00 control: bit 0 engine on, bit 1 interrupt on, bits 15:8 threshold.
- 0x04 and 0x08: the high and low halves of the head timestamp.
- 0x0C: head slice index in bits 23:16.
- 0x10: head value after the change.
- 0x14: head value before the change.
- 0x1C: command port.
- 0x20 status: occupancy in bits 15:8, overflow flag in bit 0.
- 0x40 + n*0x20: enable word of slice n.

Top module: `edge_stamp_engine`

## Requirements
- R1: After reset, control reads 0x0000_0100: engine off, interrupt off, threshold 1. Status reads 0, every slice enable word reads 0, and irq_o is low.
- R2: A change of an enabled line while the engine is on produces one queued event. That event reports the slice index in bits 23:16 of 0x0C, the slice's whole 32-bit value before the change at 0x14, and its value after the change at 0x10.
- R3: No event is queued for a change on a line whose enable bit is 0, nor for any change while control bit 0 is 0.
- R4: All enabled lines of one slice that change in the same cycle share a single event.
- R5: When several slices change in the same cycle, each gets its own event. The events enter the queue in ascending slice order on consecutive cycles, so their timestamps differ by 1.
- R6: The timestamp is a 64-bit count that advances by one each clock. It is read as the high word at 0x04 and the low word at 0x08. Two events' timestamps differ by the number of cycles between their changes.
- R7: Status bits 15:8 give the queue occupancy. Writing exactly 1 to 0x1C drops the head event. Any other value written there, or a pop on an empty queue, changes nothing.
- R8: The queue holds 16 events. An event that arrives while it is full is discarded and sets status bit 0. That bit stays set until 1 is written to status bit 0.
- R9: irq_o is high exactly when control bit 1 is set, the occupancy is non-zero, and the occupancy is at or above the threshold in control bits 15:8.
- R10: While the queue is empty, the head registers at 0x04, 0x08, 0x0C, 0x10 and 0x14 read zero.
- R11: The enable word of slice n lives at 0x40 + n*0x20, with bit b controlling global line n*32+b. It reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_i | input | NUM_SLICES*32 | Watched lines, already synchronised; slice n is bits n*32+31:n*32 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench changes lines in two slices within the same cycle. A design that merged them into one event, or that lost the second slice, leaves the scoreboard with missing entries or entries with the wrong slice index or snapshot. It toggles lines that are not enabled and toggles lines while the engine is off; a design that ignored either gate queues entries the scoreboard never expected. It drives seventeen events into the sixteen-entry queue, then checks the occupancy, the sticky flag and its write-one clear. A wrapping pointer would show up there as corrupted heads. It also sweeps the threshold and the interrupt enable around the current occupancy, which exposes an off-by-one compare as a wrongly timed irq_o.

// File: rtl/esteng_pkg.sv
package esteng_pkg;

    localparam int SLICE_W = 32;
    localparam int TS_W    = 64;
    localparam int IDX_W   = 8;

    // Register byte offsets
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_TS_HI  = 'h04;
    localparam int OFF_TS_LO  = 'h08;
    localparam int OFF_SRC    = 'h0C;
    localparam int OFF_NEW    = 'h10;
    localparam int OFF_OLD    = 'h14;
    localparam int OFF_CMD    = 'h1C;
    localparam int OFF_STATUS = 'h20;
    localparam int OFF_ENA    = 'h40;
    localparam int ENA_STRIDE = 'h20;

    localparam logic [31:0] CMD_POP = 32'd1;

    typedef struct packed {
        logic [TS_W-1:0]    ts;
        logic [IDX_W-1:0]   slice;
        logic [SLICE_W-1:0] old_val;
        logic [SLICE_W-1:0] new_val;
    } stamp_entry_t;

endpackage

// File: rtl/esteng_tick_counter.sv
module esteng_tick_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] tick_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.cnt;

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tick_o == $past(tick_o) + W'(1)); // R6

endmodule

// File: rtl/esteng_change_detect.sv
module esteng_change_detect
    import esteng_pkg::*;
#(
    parameter int NUM_SLICES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] lines_i,
    input  logic [NUM_SLICES*SLICE_W-1:0] mask_i,
    input  logic                          eng_en_i,
    input  logic                          full_i,
    input  logic [TS_W-1:0]               ts_i,
    output logic                          push_o,
    output logic                          drop_o,
    output stamp_entry_t                  entry_o
);

    localparam int SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

    typedef struct packed {
        logic [NUM_SLICES-1:0][SLICE_W-1:0] last;
    } det_st_t;

    det_st_t s_d, s_q;

    logic [NUM_SLICES-1:0][SLICE_W-1:0] lines_a, mask_a;
    logic [NUM_SLICES-1:0]              chg;
    logic [SEL_W-1:0]                   sel;
    logic                               sel_v;

    assign lines_a = lines_i;
    assign mask_a  = mask_i;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        assign chg[s] = eng_en_i && (|((lines_a[s] ^ s_q.last[s]) & mask_a[s]));
    end

    // Lowest pending slice is served first; others keep their old snapshot
    always_comb begin
        sel   = '0;
        sel_v = 1'b0;
        for (int s = NUM_SLICES - 1; s >= 0; s--) begin
            if (chg[s]) begin
                sel   = SEL_W'(s);
                sel_v = 1'b1;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (!chg[s] || (sel == SEL_W'(s))) s_d.last[s] = lines_a[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        entry_o         = '0;
        entry_o.ts      = ts_i;
        entry_o.slice   = IDX_W'(sel);
        entry_o.old_val = s_q.last[sel];
        entry_o.new_val = lines_a[sel];
    end

    assign push_o = sel_v && !full_i;
    assign drop_o = sel_v && full_i;

endmodule

// File: rtl/esteng_event_fifo.sv
module esteng_event_fifo
    import esteng_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  stamp_entry_t entry_i,
    input  logic         pop_i,
    output stamp_entry_t head_o,
    output logic [CNT_W-1:0] count_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     s_d, s_q;
    stamp_entry_t mem_q [DEPTH];
    logic         do_push, do_pop;

    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + PTR_W'(1);
        if (do_pop)  s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + PTR_W'(1);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= entry_i;
    end

    assign head_o  = mem_q[s_q.rd];
    assign count_o = s_q.cnt;

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH)); // R8

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R8

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> count_o == $past(count_o) - CNT_W'(1)); // R7

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o); // R7

endmodule

// File: rtl/edge_stamp_engine.sv
module edge_stamp_engine
    import esteng_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] lines_i,
    input  logic                          reg_wr_i,
    input  logic [ADDR_W-1:0]             reg_addr_i,
    input  logic [31:0]                   reg_wdata_i,
    output logic [31:0]                   reg_rdata_o,
    output logic                          irq_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

    typedef struct packed {
        logic                               eng_en;
        logic                               irq_en;
        logic [7:0]                         thr;
        logic                               ovf;
        logic [NUM_SLICES-1:0][SLICE_W-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [TS_W-1:0]   tick;
    logic              det_push, det_drop;
    stamp_entry_t      det_entry, head_raw, head;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_empty, fifo_full;
    logic              pop;
    logic [7:0]        occ;

    // Enable-word address decode
    logic [ADDR_W-1:0] ena_off;
    logic [ADDR_W-1:0] ena_idx_full;
    logic              ena_hit;
    logic [SEL_W-1:0]  ena_idx;

    assign ena_off      = reg_addr_i - ADDR_W'(OFF_ENA);
    assign ena_idx_full = ena_off >> $clog2(ENA_STRIDE);
    assign ena_idx      = ena_idx_full[SEL_W-1:0];
    assign ena_hit      = (reg_addr_i >= ADDR_W'(OFF_ENA))
                       && (ena_off[$clog2(ENA_STRIDE)-1:0] == '0)
                       && (ena_idx_full < ADDR_W'(NUM_SLICES));

    esteng_tick_counter #(.W(TS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    esteng_change_detect #(.NUM_SLICES(NUM_SLICES)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (lines_i),
        .mask_i   (r_q.mask),
        .eng_en_i (r_q.eng_en),
        .full_i   (fifo_full),
        .ts_i     (tick),
        .push_o   (det_push),
        .drop_o   (det_drop),
        .entry_o  (det_entry)
    );

    esteng_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (det_push),
        .entry_i (det_entry),
        .pop_i   (pop),
        .head_o  (head_raw),
        .count_o (fifo_count),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    // Register writes and sticky overflow
    always_comb begin
        r_d = r_q;
        pop = 1'b0;
        if (reg_wr_i) begin
            if (reg_addr_i == ADDR_W'(OFF_CTRL)) begin
                r_d.eng_en = reg_wdata_i[0];
                r_d.irq_en = reg_wdata_i[1];
                r_d.thr    = reg_wdata_i[15:8];
            end else if (reg_addr_i == ADDR_W'(OFF_STATUS)) begin
                if (reg_wdata_i[0]) r_d.ovf = 1'b0;
            end else if (reg_addr_i == ADDR_W'(OFF_CMD)) begin
                pop = (reg_wdata_i == CMD_POP);
            end else if (ena_hit) begin
                r_d.mask[ena_idx] = reg_wdata_i;
            end
        end
        if (det_drop) r_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.thr <= 8'd1;
        end else begin
            r_q <= r_d;
        end
    end

    assign head = fifo_empty ? '0 : head_raw;
    assign occ  = 8'(fifo_count);

    // Register reads
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(OFF_CTRL)) begin
            reg_rdata_o[0]    = r_q.eng_en;
            reg_rdata_o[1]    = r_q.irq_en;
            reg_rdata_o[15:8] = r_q.thr;
        end else if (reg_addr_i == ADDR_W'(OFF_TS_HI)) begin
            reg_rdata_o = head.ts[63:32];
        end else if (reg_addr_i == ADDR_W'(OFF_TS_LO)) begin
            reg_rdata_o = head.ts[31:0];
        end else if (reg_addr_i == ADDR_W'(OFF_SRC)) begin
            reg_rdata_o[23:16] = head.slice;
        end else if (reg_addr_i == ADDR_W'(OFF_NEW)) begin
            reg_rdata_o = head.new_val;
        end else if (reg_addr_i == ADDR_W'(OFF_OLD)) begin
            reg_rdata_o = head.old_val;
        end else if (reg_addr_i == ADDR_W'(OFF_STATUS)) begin
            reg_rdata_o[15:8] = occ;
            reg_rdata_o[0]    = r_q.ovf;
        end else if (ena_hit) begin
            reg_rdata_o = r_q.mask[ena_idx];
        end
    end

    assign irq_o = r_q.irq_en && !fifo_empty && (occ >= r_q.thr);

    AST_NO_PUSH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.eng_en |-> !(det_push || det_drop)); // R3

    AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !fifo_empty); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !(reg_wr_i && reg_addr_i == ADDR_W'(OFF_STATUS) && reg_wdata_i[0]))
        |=> r_q.ovf); // R8

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        det_drop |-> fifo_count == CNT_W'(FIFO_DEPTH)); // R8

endmodule

// File: tb/edge_stamp_engine_tb_top.sv
module edge_stamp_engine_tb_top;

    localparam int NS    = 2;
    localparam int DEPTH = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS*32-1:0] lines = '0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;

    always #2 clk = ~clk;

    edge_stamp_engine #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH), .ADDR_W(8)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_i     (lines),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          slice;
        logic [31:0] old_v;
        logic [31:0] new_v;
        int          tag;
    } exp_t;

    exp_t        sbq[$];
    logic [63:0] ts_off;
    bit          off_set = 0;
    bit          m_on = 0;
    logic [31:0] m_mask [NS];
    int          m_cnt = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver: apply new line values and queue the events the requirements predict
    task automatic change(input logic [NS*32-1:0] nl);
        int k = 0;
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            if (m_on && (((nl[s*32 +: 32] ^ lines[s*32 +: 32]) & m_mask[s]) != 0)) begin
                if (m_cnt < DEPTH) begin
                    exp_t e;
                    e.slice = s;
                    e.old_v = lines[s*32 +: 32];
                    e.new_v = nl[s*32 +: 32];
                    e.tag   = cyc + 1 + k;
                    sbq.push_back(e);
                    m_cnt++;
                end
                k++;
            end
        end
        lines = nl;
        repeat (NS + 1) @(negedge clk);
    endtask

    // Monitor: compare the head against the scoreboard, then pop it
    task automatic take_one();
        exp_t e;
        logic [31:0] hi, lo, src, nv, ov;
        logic [63:0] ts;
        e = sbq.pop_front();
        rd(8'h04, hi);
        rd(8'h08, lo);
        rd(8'h0C, src);
        rd(8'h10, nv);
        rd(8'h14, ov);
        check("R2", "slice", 64'(src[23:16]), 64'(e.slice));
        check("R2", "new value", 64'(nv), 64'(e.new_v));
        check("R2", "old value", 64'(ov), 64'(e.old_v));
        ts = {hi, lo};
        if (!off_set) begin
            ts_off  = ts - 64'(e.tag);
            off_set = 1;
        end else begin
            check("R6", "timestamp vs change cycle", ts - 64'(e.tag), ts_off);
        end
        wr(8'h1C, 32'd1);
        m_cnt--;
    endtask

    task automatic drain();
        logic [31:0] st;
        while (sbq.size() > 0) take_one();
        rd(8'h20, st);
        check("R7", "occupancy after drain", 64'(st[15:8]), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_mask[0] = '0;
        m_mask[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 empty head reads zero
        rd(8'h00, d); check("R1", "ctrl reset", 64'(d), 64'h100);
        rd(8'h20, d); check("R1", "status reset", 64'(d), 64'h0);
        rd(8'h40, d); check("R1", "enable0 reset", 64'(d), 64'h0);
        check("R1", "irq reset", 64'(irq), 64'h0);
        rd(8'h04, d); check("R10", "empty ts hi", 64'(d), 64'h0);
        rd(8'h08, d); check("R10", "empty ts lo", 64'(d), 64'h0);
        rd(8'h10, d); check("R10", "empty new", 64'(d), 64'h0);

        // R11 enable words at 0x40 + n*0x20
        wr(8'h40, 32'h0000_00FF); m_mask[0] = 32'h0000_00FF;
        wr(8'h60, 32'h8000_0001); m_mask[1] = 32'h8000_0001;
        rd(8'h40, d); check("R11", "enable slice0", 64'(d), 64'h0000_00FF);
        rd(8'h60, d); check("R11", "enable slice1", 64'(d), 64'h8000_0001);

        // R3 engine off: no event
        change(64'h0000_0000_0000_0001);
        rd(8'h20, d); check("R3", "no event while off", 64'(d[15:8]), 64'd0);

        // R3 line not enabled: no event
        wr(8'h00, 32'h0000_0101); m_on = 1;
        change(64'h0000_0000_0000_0101);
        rd(8'h20, d); check("R3", "no event on masked line", 64'(d[15:8]), 64'd0);

        // R4 two enabled lines of slice 0 in one cycle share an entry
        change(64'h0000_0000_0000_0108);
        rd(8'h20, d); check("R4", "one entry for two lines", 64'(d[15:8]), 64'd1);

        // R5 two slices in one cycle -> two entries, ascending order
        change(64'h8000_0000_0000_010A);
        rd(8'h20, d); check("R5", "two slices two entries", 64'(d[15:8]), 64'd3);

        // R6 later single change
        repeat (5) @(negedge clk);
        change(64'h8000_0001_0000_010A);
        rd(8'h20, d); check("R7", "occupancy four", 64'(d[15:8]), 64'd4);

        // R7 command value other than 1 is ignored
        wr(8'h1C, 32'd2);
        rd(8'h20, d); check("R7", "non-pop command ignored", 64'(d[15:8]), 64'd4);
        drain();

        // R7 pop on empty is ignored
        wr(8'h1C, 32'd1);
        rd(8'h20, d); check("R7", "pop on empty", 64'(d[15:8]), 64'd0);
        rd(8'h0C, d); check("R10", "empty src", 64'(d), 64'h0);

        // R9 interrupt threshold
        wr(8'h00, 32'h0000_0303);
        change(64'h8000_0001_0000_010B);
        change(64'h8000_0001_0000_010A);
        check("R9", "irq below threshold", 64'(irq), 64'd0);
        change(64'h8000_0001_0000_010B);
        check("R9", "irq at threshold", 64'(irq), 64'd1);
        take_one();
        check("R9", "irq after pop below threshold", 64'(irq), 64'd0);
        wr(8'h00, 32'h0000_0203);
        check("R9", "irq lower threshold", 64'(irq), 64'd1);
        wr(8'h00, 32'h0000_0201);
        check("R9", "irq disabled", 64'(irq), 64'd0);
        drain();
        check("R9", "irq when empty", 64'(irq), 64'd0);

        // R8 overflow: 17 events into 16 entries
        wr(8'h00, 32'h0000_0101);
        for (int i = 0; i < DEPTH + 1; i++) begin
            change(lines ^ 64'h1);
        end
        rd(8'h20, d);
        check("R8", "occupancy full", 64'(d[15:8]), 64'd16);
        check("R8", "overflow flag set", 64'(d[0]), 64'd1);
        wr(8'h20, 32'h0);
        rd(8'h20, d); check("R8", "overflow kept on write 0", 64'(d[0]), 64'd1);
        drain();
        wr(8'h20, 32'h1);
        rd(8'h20, d); check("R8", "overflow cleared", 64'(d[0]), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule